// File: doc/BRIEF.md
# Down-Counting PWM Pulse Generator

This block produces a periodic rectangular wave from a count-tick enable. Software loads a period value m and a high-width value n through a small write port. Once running, an internal down counter steps once per tick from m to 1. The output source is active while the count is at or below n. On the tick after the count of 1, the counter reloads and a new period begins. The result is a wave of m ticks per period with n active ticks at the end of each period. For a 50% duty cycle, set n to m/2.

A run input starts and stops the wave. While stopped, the output source is held inactive and the counter rests at the period value, so every start begins a full period. Period and width changes written while running are held in shadow copies and only take effect at the next reload, so a period is never cut short. A polarity input inverts the pin. Everything runs on one clock with a synchronous reset, and the tick is a one-cycle enable in that clock domain.

Top module: `pwm_gen`

## Requirements
- R1: After synchronous reset the period and width settings are 0, the generator is stopped, and the pin equals the `invert` input (source inactive).
- R2: While running with period m in 1..255, the counter takes the values m, m-1, ..., 1, one per tick, and reloads to m on the tick after 1, so the wave repeats every m ticks; a period setting of 0 behaves as 1.
- R3: With 1 <= n < m, the source is active exactly while the counter value is at or below n, i.e. for the last n ticks of each m-tick period.
- R4: A width setting of 0 keeps the source inactive at all times.
- R5: A width setting greater than or equal to the period keeps the source active for the whole time the generator runs.
- R6: The pin equals the source XOR `invert` at all times, whether running or stopped.
- R7: Clearing `run_en` makes the source inactive from the next clock, and the counter returns to the period value; a later start begins again at state m.
- R8: The counter advances only on clocks where `tick` is 1 while running; ticks while stopped and clocks without a tick change nothing.
- R9: A write with `wr_sel`=0 sets the period and with `wr_sel`=1 sets the width; a write made while running takes effect at the next reload, not within the current period.
- R10: `run_en` is sampled into a register; a tick that arrives in the same clock as the first high sample of `run_en` is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the setting registers |
| wr_sel | input | 1 | Target register: 0 period, 1 high width |
| wr_data | input | W | Value to write |
| run_en | input | 1 | 1 runs the generator, 0 stops it |
| invert | input | 1 | 1 inverts the pin relative to the source |
| tick | input | 1 | One-cycle count enable |
| pwm_out | output | 1 | Pulse output pin |

## Verification
The main function is tried with a set of (m, n) pairs: a mid-range width, an exact half period, a single-tick width, zero width, width equal to and above the period, a one-tick period, and a zero period. Together they separate the compare that sets the active state from the reload point and from the clamped corner cases. Every state of two full periods is checked, so a count that starts at m-1 or reloads one tick late shows up as a shifted pattern. Some pairs run with inversion on, which separates the polarity stage from the source logic. Directed sequences cover writes during a period, stopping mid-period, ticks while stopped, idle clocks between ticks, and a tick that coincides with the start.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_HIGH   = 1'b1
    } pwm_sel_e;

endpackage

// File: rtl/pwm_setting_regs.sv
module pwm_setting_regs
    import pwm_gen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         running,
    input  logic         reload,
    output logic [W-1:0] load_val,
    output logic [W-1:0] period_act,
    output logic [W-1:0] high_act
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] period_cfg;
        logic [W-1:0] high_cfg;
        logic [W-1:0] period_act;
        logic [W-1:0] high_act;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [W-1:0] clamped;

    always_comb begin
        clamped = (regs_q.period_cfg == '0) ? ONE : regs_q.period_cfg;
        regs_d  = regs_q;
        if (wr_en) begin
            if (pwm_sel_e'(wr_sel) == SEL_PERIOD) regs_d.period_cfg = wr_data;
            else                                  regs_d.high_cfg   = wr_data;
        end
        if (!running || reload) begin
            regs_d.period_act = clamped;
            regs_d.high_act   = regs_q.high_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.period_cfg <= '0;
            regs_q.high_cfg   <= '0;
            regs_q.period_act <= ONE;
            regs_q.high_act   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign load_val   = clamped;
    assign period_act = regs_q.period_act;
    assign high_act   = regs_q.high_act;

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         tick,
    input  logic [W-1:0] load_val,
    output logic         running,
    output logic [W-1:0] count,
    output logic         reload
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic last_state;

    always_comb begin
        last_state = (cnt_q.cnt <= ONE);
        cnt_d      = cnt_q;
        cnt_d.run  = run_en;
        if (!cnt_q.run) begin
            cnt_d.cnt = load_val;
        end else if (tick) begin
            cnt_d.cnt = last_state ? load_val : cnt_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q.run <= 1'b0;
            cnt_q.cnt <= ONE;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign running = cnt_q.run;
    assign count   = cnt_q.cnt;
    assign reload  = cnt_q.run & tick & last_state;

endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage #(
    parameter int W = 8
) (
    input  logic         running,
    input  logic         invert,
    input  logic [W-1:0] count,
    input  logic [W-1:0] high_act,
    output logic         src,
    output logic         pin
);

    always_comb begin
        src = running && (high_act != '0) && (count <= high_act);
        pin = src ^ invert;
    end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         run_en,
    input  logic         invert,
    input  logic         tick,
    output logic         pwm_out
);

    logic         run_q;
    logic         reload;
    logic [W-1:0] cnt_q;
    logic [W-1:0] load_val;
    logic [W-1:0] period_act;
    logic [W-1:0] high_act;
    logic         src;

    pwm_setting_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .running    (run_q),
        .reload     (reload),
        .load_val   (load_val),
        .period_act (period_act),
        .high_act   (high_act)
    );

    pwm_down_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .tick     (tick),
        .load_val (load_val),
        .running  (run_q),
        .count    (cnt_q),
        .reload   (reload)
    );

    pwm_pin_stage #(.W(W)) u_pin (
        .running  (run_q),
        .invert   (invert),
        .count    (cnt_q),
        .high_act (high_act),
        .src      (src),
        .pin      (pwm_out)
    );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         run_q,
    input logic         invert,
    input logic [W-1:0] cnt,
    input logic [W-1:0] load_val,
    input logic [W-1:0] period_act,
    input logic [W-1:0] high_act,
    input logic         src,
    input logic         pin
);

    assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && cnt == W'(1)) |=> (cnt == $past(load_val)));

    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && !tick) |=> $stable(cnt));

    assert_zero_width_R4: assert property (@(posedge clk) disable iff (rst)
        (high_act == '0) |-> !src);

    assert_full_width_R5: assert property (@(posedge clk) disable iff (rst)
        (run_q && high_act != '0 && high_act >= period_act) |-> src);

    assert_polarity_R6: assert property (@(posedge clk) disable iff (rst)
        pin == (src ^ invert));

    assert_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !src);

    assert_shadow_R9: assert property (@(posedge clk) disable iff (rst)
        (run_q && !(tick && cnt == W'(1))) |=> ($stable(high_act) && $stable(period_act)));

endmodule

bind pwm_gen pwm_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run_q      (run_q),
    .invert     (invert),
    .cnt        (cnt_q),
    .load_val   (load_val),
    .period_act (period_act),
    .high_act   (high_act),
    .src        (src),
    .pin        (pwm_out)
);

// File: tb/pwm_gen_bench.sv
`timescale 1ns/1ps
module pwm_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       run_en = 1'b0;
    logic       invert = 1'b0;
    logic       tick = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_gen #(.W(8)) u_pwm_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .run_en  (run_en),
        .invert  (invert),
        .tick    (tick),
        .pwm_out (pwm_out)
    );

    // {period m, width n}
    localparam int NVEC = 9;
    localparam logic [15:0] VECS [0:NVEC-1] = '{
        16'h0504, 16'h0402, 16'h0801, 16'h0600, 16'h0303,
        16'h0307, 16'h0101, 16'h0A05, 16'h0001
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic stop_gen();
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_gen();
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic src_of(input int state, input int n);
        return (n != 0) && (state <= n);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(pwm_out, 1'b0, "R1 reset pin");
        invert = 1'b1;
        #1 check(pwm_out, 1'b1, "R1 reset pin inverted");
        invert = 1'b0;
        start_gen();
        do_tick();
        do_tick();
        check(pwm_out, 1'b0, "R1 reset settings zero width");
        stop_gen();

        // Vector table: two full periods, every state checked
        for (int v = 0; v < NVEC; v++) begin
            int m, n, meff;
            string tag;
            m = int'(VECS[v][15:8]);
            n = int'(VECS[v][7:0]);
            meff = (m == 0) ? 1 : m;
            invert = v[0];
            if (m == 0) tag = "R2 zero period";
            else if (n == 0) tag = "R4 zero width";
            else if (n >= m) tag = "R5 full width";
            else tag = "R3 width";
            stop_gen();
            write_reg(1'b0, 8'(m));
            write_reg(1'b1, 8'(n));
            start_gen();
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < meff; k++) begin
                    check(pwm_out, src_of(meff - k, n) ^ invert,
                          invert ? {tag, " R6 inverted"} : {tag, " R2"});
                    do_tick();
                end
            end
        end
        invert = 1'b0;

        // R9: writes during a period apply at the next reload
        stop_gen();
        write_reg(1'b0, 8'd6);
        write_reg(1'b1, 8'd2);
        start_gen();
        do_tick();
        do_tick();
        write_reg(1'b0, 8'd4);
        write_reg(1'b1, 8'd4);
        for (int s = 4; s >= 1; s--) begin
            check(pwm_out, src_of(s, 2), "R9 old settings kept");
            do_tick();
        end
        for (int s = 4; s >= 1; s--) begin
            check(pwm_out, 1'b1, "R9 new settings after reload");
            do_tick();
        end

        // R7 / R8: stop mid-period, ticks while stopped, restart at m
        stop_gen();
        write_reg(1'b0, 8'd5);
        write_reg(1'b1, 8'd2);
        start_gen();
        do_tick();
        do_tick();
        do_tick();
        check(pwm_out, 1'b1, "R3 state two active");
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(pwm_out, 1'b0, "R7 inactive after stop");
        do_tick();
        do_tick();
        do_tick();
        check(pwm_out, 1'b0, "R8 ticks ignored while stopped");
        start_gen();
        for (int s = 5; s >= 1; s--) begin
            check(pwm_out, src_of(s, 2), "R7 restart from period");
            do_tick();
        end
        check(pwm_out, 1'b0, "R7 R2 reload after restart");

        // R8: idle clocks between ticks do not advance
        stop_gen();
        write_reg(1'b0, 8'd4);
        write_reg(1'b1, 8'd2);
        start_gen();
        do_tick();
        do_tick();
        check(pwm_out, 1'b1, "R8 state two active");
        repeat (5) @(negedge clk);
        check(pwm_out, 1'b1, "R8 idle clocks hold");
        do_tick();
        check(pwm_out, 1'b1, "R8 state one active");
        do_tick();
        check(pwm_out, 1'b0, "R8 R2 reload to four");

        // R10: tick in the same clock as the first run sample is not counted
        stop_gen();
        write_reg(1'b0, 8'd3);
        write_reg(1'b1, 8'd1);
        @(negedge clk);
        run_en = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(pwm_out, 1'b0, "R10 state three");
        do_tick();
        check(pwm_out, 1'b0, "R10 state two");
        do_tick();
        check(pwm_out, 1'b1, "R10 state one");

        // R1: synchronous reset while running
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_en = 1'b0;
        check(pwm_out, 1'b0, "R1 reset while running");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule